// File: doc/BRIEF.md
# Switchable Four-Stage Data Pipeline Register

This block is a bank of four data registers that can work as one deep pipeline or as two short, independent pipelines. A 2-bit operation code, sampled on each rising clock edge, picks one of four behaviours:

- chain all four registers into a single four-stage pipeline;
- advance only the upper pair;
- advance only the lower pair;
- freeze every register.

The operation code can change on every cycle, so a datapath can, for example, fill the chain and then let one half run while the other half keeps a captured value.

Any of the four registers can be read at any time through a combinational select multiplexer. An active-low output enable controls whether the selected word is presented. In place of a tri-state pin, the output carries a drive flag. While the output is disabled, the data lines read zero.

The registers are named by pair and level. The upper pair is `hi1` (first level) and `hi2` (second level). The lower pair is `lo1` and `lo2`. Both the pair depth and the data width are parameters. The defaults are 8 bits and two levels per pair.

Top module: `multilevel_pipe_reg`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, all four registers become zero. This reset is synchronous.
- R2: The registers change only at a rising clock edge. A change on `din` between edges does not change `y`. `sel` and `oe_n` act combinationally, without a clock.
- R3: Operation code 0 (`op`=2'b00) advances the whole chain on one edge, as follows:
  - `din` goes into hi1;
  - hi1 goes into hi2;
  - hi2 goes into lo1;
  - lo1 goes into lo2.
- R4: Operation code 2 (`op`=2'b10) advances only the upper pair: `din` goes into hi1 and hi1 goes into hi2. lo1 and lo2 keep their values.
- R5: Operation code 1 (`op`=2'b01) advances only the lower pair: `din` goes into lo1 and lo1 goes into lo2. hi1 and hi2 keep their values.
- R6: Operation code 3 (`op`=2'b11) holds. No register changes at the edge, whatever `din` is.
- R7: The `sel` codes choose which register drives `y`:

  | `sel` | Register on `y` |
  |---|---|
  | 2'b11 | hi1 |
  | 2'b10 | hi2 |
  | 2'b01 | lo1 |
  | 2'b00 | lo2 |

- R8: While `oe_n` is high, `y_en` is 0 and `y` is all zeros. While `oe_n` is low, `y_en` is 1 and `y` carries the selected register.
- R9: The operation code may differ on consecutive edges. Each edge applies the code sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 2 | Operation code: 0 chain, 1 lower pair, 2 upper pair, 3 hold |
| din | input | WIDTH | Data word shifted into the first level |
| sel | input | 2 | Read select: 3 hi1, 2 hi2, 1 lo1, 0 lo2 |
| oe_n | input | 1 | Active-low output enable |
| y | output | WIDTH | Selected register word, zero while disabled |
| y_en | output | 1 | Output drive flag, high while enabled |

## Verification
The hardest situation to reach from the ports is a pair whose contents were built under one operation and are then left alone while the other pair runs. Reaching it needs the operation code to change across edges in every order. The sweep therefore steps the operation code through a sequence in which every code follows every other code. Fresh, distinct data is driven at each edge, and all four registers are read back through every select code after each edge. This way, a register that is wrongly disturbed shows up as a stale or foreign word. A reset in the middle of the sweep, applied with the chain operation and non-zero data, confirms that reset takes precedence over shifting.

// File: rtl/mpr_pkg.sv
// Package: shared encodings for the switchable pipeline register.
// Assumes a 2-bit operation code sampled on the rising clock edge.
package mpr_pkg;

    typedef enum logic [1:0] {
        OP_CHAIN = 2'd0,   // all four registers form one chain
        OP_LOW   = 2'd1,   // only the lower pair advances
        OP_HIGH  = 2'd2,   // only the upper pair advances
        OP_HOLD  = 2'd3    // nothing moves
    } op_e;

    // Per-edge control produced by the decoder
    typedef struct packed {
        logic adv_hi;      // upper pair advances this edge
        logic adv_lo;      // lower pair advances this edge
        logic lo_from_hi;  // lower pair head takes the upper tail, else din
    } step_ctl_t;

endpackage

// File: rtl/mpr_decode.sv
// Module: mpr_decode
// Turns the operation code into per-pair advance enables and the
// source choice for the head of the lower pair. Purely combinational;
// assumes op is stable around the sampling edge.
module mpr_decode
    import mpr_pkg::*;
(
    input  logic [1:0] op,
    output step_ctl_t  ctl
);

    // Decode the operation code into advance controls
    always_comb begin
        ctl = '0;
        case (op_e'(op))
            OP_CHAIN: begin
                ctl.adv_hi     = 1'b1;
                ctl.adv_lo     = 1'b1;
                ctl.lo_from_hi = 1'b1;
            end
            OP_LOW:  ctl.adv_lo = 1'b1;
            OP_HIGH: ctl.adv_hi = 1'b1;
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mpr_row.sv
// Module: mpr_row
// One shift row of DEPTH registers, WIDTH bits each. When adv is high,
// head enters level 0 and every level moves one step deeper. When adv
// is low, the row keeps its contents. The reset is synchronous and
// active-low.
module mpr_row #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adv,
    input  logic [WIDTH-1:0]             head,
    output logic [DEPTH-1:0][WIDTH-1:0]  q
);

    // Clear, shift or keep the row on each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (adv) begin
            q[0] <= head;
            for (int k = 1; k < DEPTH; k++) begin
                q[k] <= q[k-1];
            end
        end
    end

endmodule

// File: rtl/mpr_out_sel.sv
// Module: mpr_out_sel
// Read multiplexer over the flattened register bank. The bank is
// indexed with the upper pair first, from level 1 down to the deepest
// lower level. A select code of value c reads bank entry REGS-1-c.
// Codes with no matching entry read zero. While the output is
// disabled, the data reads zero and the drive flag is low.
module mpr_out_sel #(
    parameter int WIDTH = 8,
    parameter int REGS  = 4,
    parameter int SELW  = 2
) (
    input  logic [REGS-1:0][WIDTH-1:0] bank,
    input  logic [SELW-1:0]            sel,
    input  logic                       oe_n,
    output logic [WIDTH-1:0]           y,
    output logic                       y_en
);

    // Pick the addressed entry and apply the output enable
    always_comb begin
        y    = '0;
        y_en = ~oe_n;
        if (!oe_n) begin
            for (int k = 0; k < REGS; k++) begin
                if (int'(sel) == REGS - 1 - k) begin
                    y = bank[k];
                end
            end
        end
    end

endmodule

// File: rtl/multilevel_pipe_reg.sv
// Module: multilevel_pipe_reg (top)
// Two rows of LEVELS registers: the upper pair (hi) and the lower pair
// (lo). Each edge either chains them into one pipeline, advances one
// row alone, or holds both. Any register can be read through sel.
// Assumes a single clock and synchronous active-low reset.
module multilevel_pipe_reg
    import mpr_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int LEVELS = 2,
    localparam int REGS  = 2 * LEVELS,
    localparam int SELW  = $clog2(REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] din,
    input  logic [SELW-1:0]  sel,
    input  logic             oe_n,
    output logic [WIDTH-1:0] y,
    output logic             y_en
);

    step_ctl_t                       ctl;
    logic [LEVELS-1:0][WIDTH-1:0]    hi_q;
    logic [LEVELS-1:0][WIDTH-1:0]    lo_q;
    logic [WIDTH-1:0]                lo_head;
    logic [REGS-1:0][WIDTH-1:0]      bank;

    mpr_decode u_decode (
        .op  (op),
        .ctl (ctl)
    );

    // Lower pair head: upper tail in chain mode, else the input word
    always_comb begin
        lo_head = ctl.lo_from_hi ? hi_q[LEVELS-1] : din;
    end

    mpr_row #(.WIDTH(WIDTH), .DEPTH(LEVELS)) u_row_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ctl.adv_hi),
        .head  (din),
        .q     (hi_q)
    );

    mpr_row #(.WIDTH(WIDTH), .DEPTH(LEVELS)) u_row_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ctl.adv_lo),
        .head  (lo_head),
        .q     (lo_q)
    );

    // Flatten both rows into one bank, upper row first
    for (genvar g = 0; g < LEVELS; g++) begin : g_bank
        assign bank[g]          = hi_q[g];
        assign bank[LEVELS + g] = lo_q[g];
    end

    mpr_out_sel #(.WIDTH(WIDTH), .REGS(REGS), .SELW(SELW)) u_out (
        .bank (bank),
        .sel  (sel),
        .oe_n (oe_n),
        .y    (y),
        .y_en (y_en)
    );

endmodule

// File: rtl/mpr_checker.sv
// Module: mpr_checker
// Property checks on the pipeline register, bound into the top module.
// It observes the row contents and the ports. Assumes LEVELS >= 1.
module mpr_checker #(
    parameter int WIDTH  = 8,
    parameter int LEVELS = 2,
    parameter int SELW   = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  op,
    input logic [WIDTH-1:0]            din,
    input logic [SELW-1:0]             sel,
    input logic                        oe_n,
    input logic [WIDTH-1:0]            y,
    input logic                        y_en,
    input logic [LEVELS-1:0][WIDTH-1:0] hi_q,
    input logic [LEVELS-1:0][WIDTH-1:0] lo_q
);

    // R3: chain mode feeds din to hi1 and the upper tail to lo1
    assert_chain_heads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'd0 |=> hi_q[0] == $past(din) && lo_q[0] == $past(hi_q[LEVELS-1]));

    // R4: upper-only mode keeps the lower pair and loads hi1
    assert_upper_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'd2 |=> $stable(lo_q) && hi_q[0] == $past(din));

    // R5: lower-only mode keeps the upper pair and loads lo1
    assert_lower_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'd1 |=> $stable(hi_q) && lo_q[0] == $past(din));

    // R6: hold freezes every register
    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'd3 |=> $stable(hi_q) && $stable(lo_q));

    // R7: the highest select code reads hi1
    assert_sel_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n && sel == SELW'(2 * LEVELS - 1) |-> y == hi_q[0]);

    // R8: a disabled output shows zero data and no drive
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !y_en && y == '0);

endmodule

bind multilevel_pipe_reg mpr_checker #(
    .WIDTH  (WIDTH),
    .LEVELS (LEVELS),
    .SELW   (SELW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .din   (din),
    .sel   (sel),
    .oe_n  (oe_n),
    .y     (y),
    .y_en  (y_en),
    .hi_q  (hi_q),
    .lo_q  (lo_q)
);

// File: tb/multilevel_pipe_reg_bench.sv
`timescale 1ns/100ps
// Bench: sweeps all operation codes in every successive order and
// reads every register through every select code after each edge.
module multilevel_pipe_reg_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op = 2'd0;
    logic [7:0] din = 8'h00;
    logic [1:0] sel = 2'd3;
    logic       oe_n = 1'b0;
    logic [7:0] y;
    logic       y_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of hi1, hi2, lo1, lo2
    logic [7:0] m_h1 = 8'h00, m_h2 = 8'h00, m_l1 = 8'h00, m_l2 = 8'h00;

    multilevel_pipe_reg u_multilevel_pipe_reg (
        .clk (clk), .rst_n (rst_n), .op (op), .din (din),
        .sel (sel), .oe_n (oe_n), .y (y), .y_en (y_en)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pick(input logic [1:0] s);
        case (s)
            2'd3:    return m_h1;
            2'd2:    return m_h2;
            2'd1:    return m_l1;
            default: return m_l2;
        endcase
    endfunction

    task automatic chk(input string tg, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got en/data %h expected %h at %0t", tg, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, read back
    task automatic step(input logic r, input logic [1:0] o, input logic [7:0] d, input string tg);
        @(negedge clk);
        rst_n = r; op = o; din = d; sel = 2'd3; oe_n = 1'b0;
        #1;
        chk("R2 din between edges", {y_en, y}, {1'b1, m_h1});
        @(posedge clk);
        if (!r) begin
            m_h1 = 0; m_h2 = 0; m_l1 = 0; m_l2 = 0;
        end else begin
            case (o)
                2'd0: begin m_l2 = m_l1; m_l1 = m_h2; m_h2 = m_h1; m_h1 = d; end
                2'd1: begin m_l2 = m_l1; m_l1 = d; end
                2'd2: begin m_h2 = m_h1; m_h1 = d; end
                default: ;
            endcase
        end
        #0.5;
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            #0.8;
            chk({tg, "/R7"}, {y_en, y}, {1'b1, pick(2'(s))});
        end
        oe_n = 1'b1;
        #0.8;
        chk("R8 disabled", {y_en, y}, 9'h000);
    endtask

    initial begin
        logic [1:0] prev;
        string tg;
        // R1: hold reset with non-zero data and chain mode
        for (int k = 0; k < 3; k++) step(1'b0, 2'd0, 8'hA5, "R1 reset");
        prev = 2'd0;
        for (int i = 0; i < 240; i++) begin
            logic [1:0] o;
            logic       r;
            o = 2'((i + i / 4 + i / 16) % 4);
            r = (i == 150) ? 1'b0 : 1'b1;
            case (o)
                2'd0:    tg = "R3";
                2'd1:    tg = "R5";
                2'd2:    tg = "R4";
                default: tg = "R6";
            endcase
            if (!r) tg = "R1 mid-run reset";
            else if (o != prev) tg = {tg, "/R9"};
            step(r, o, 8'((i * 73 + 29) % 256), tg);
            prev = o;
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule